// File: doc/BRIEF.md
# Windowed Framebuffer Memory Bridge

The bridge is a memory-mapped slave for a virtual frame. The frame is `FRAME_W` bytes per row and `FRAME_H` rows, with one byte per pixel. Only a rectangle of `WIN_W` columns by `WIN_H` rows, fixed to the lower-right corner of that frame, has real storage behind it. That storage is packed, so consecutive window rows sit back to back with no gap.

Each bus byte address is turned into a row and column of the virtual frame. A byte that lands inside the rectangle is stored at or fetched from its packed slot. Any other byte is dropped on write and reads as zero. Halfword and word requests are broken into single-byte lanes, handled one per cycle, and each lane is tested against the rectangle on its own.

A refresh engine can follow modified pixels through a one-cycle strobe that carries the packed index. It fetches pixels through a separate read-only port, which returns the stored value both as an 8-bit level and as a grey 24-bit colour. A full-size instance uses a 1024×768 frame, a 640×264 window and a 1 MiB decode region. The defaults are scaled down to 64×48, 40×11 and 4 KiB so that the storage stays small.

Top module: `fbw_bridge`

## Requirements
- R1: After reset, busReady is 1 and dirtyValid is 0, and every storage slot reads 0 through the scan port.
- R2: A byte written at address BASE_ADDR + WIN_OFFSET + r·FRAME_W + c, where WIN_OFFSET = (FRAME_H−WIN_H)·FRAME_W + (FRAME_W−WIN_W), r < WIN_H and c < WIN_W, is stored at packed index r·WIN_W + c. A byte read at the same address returns it in busRdata[7:0], with all other bits 0.
- R3: A lane whose column (relative address mod FRAME_W) is WIN_W or more reads 0 and writes nothing. No other slot changes.
- R4: A lane whose relative address lies before the window start (a negative offset, tested as a full 32-bit unsigned value), or whose row is WIN_H or more, reads 0 and writes nothing.
- R5: reqSize selects the access width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. A request is taken on a rising edge with reqValid=1 and busReady=1. Its n lanes (address, address+1, and so on) take one cycle each, so busReady reads 0 for exactly n cycles. It returns to 1 with busRdata complete.
- R6: With littleEndian=0, the lowest address maps to the most significant byte of the n-byte value held in the low bits of reqWdata and busRdata. Upper unused read bits are 0.
- R7: With littleEndian=1, the lowest address maps to bits [7:0], and each following address maps to the next byte up.
- R8: A multi-byte access that crosses the window edge stores its in-window lanes and drops the rest. On read, the in-window lanes return data and the out-of-window lanes return 0.
- R9: Each in-window write lane drives dirtyValid high for one cycle, the cycle after that lane, with dirtyIndex equal to its packed index. Out-of-window lanes and reads drive no strobe.
- R10: A request whose address minus BASE_ADDR is REGION_BYTES or more (unsigned) is not taken: busReady stays 1, and nothing is stored or strobed.
- R11: scanData shows the slot at scanAddr one cycle after scanAddr is applied, and scanGrey repeats that byte in all three 8-bit channels. An index of WIN_W·WIN_H or more yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| littleEndian | input | 1 | 1 selects ascending lane order, 0 selects descending |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| reqAddr | input | 32 | Byte address of the lowest lane |
| reqWdata | input | 32 | Write data, right aligned |
| busReady | output | 1 | High when idle and able to take a request |
| busRdata | output | 32 | Assembled read data, valid when busReady returns high |
| dirtyValid | output | 1 | One-cycle strobe per stored byte |
| dirtyIndex | output | IDX_W ($clog2(WIN_W·WIN_H), 9 by default) | Packed index of the stored byte |
| scanAddr | input | IDX_W | Packed index to fetch for scan-out |
| scanData | output | 8 | Stored pixel level |
| scanGrey | output | 24 | Pixel level copied into three colour channels |

## Verification
The mapping is probed at the four window corners and at an interior pixel. Each result is read back through both the bus and the scan port, so a wrong row stride shows up separately from a wrong offset. Rejection is driven from every side: a column just past the right edge, the byte just before the window start, the frame's first byte, a row just past the bottom, and addresses outside the decode region. Each rejected access is followed by a check that the neighbouring slots an aliasing bug would hit are still intact. Words and halfwords are written and read in both lane orders, and the orders are crossed (written one way, read the other), which tells a lane reversal apart from an address error. A word that straddles the right edge separates per-lane checking from per-request checking.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  // Strobes sent from the lane sequencer to the datapath.
  typedef struct packed {
    logic       capture;   // request accepted this cycle: latch address/data, clear accumulator
    logic       laneEn;    // one byte lane is being processed this cycle
    logic       laneWr;    // the lane is a write
    logic [1:0] laneOff;   // byte offset of the lane from the request address
    logic [1:0] bytePos;   // byte position of the lane inside the 32-bit data word
  } laneCtl_t;

  // Number of byte lanes minus one for a size code.
  function automatic logic [1:0] lastLaneOf(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/fbw_ctrl.sv
module fbw_ctrl
  import fbw_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR    = 32'h0010_0000,
  parameter int          REGION_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqAddr,
  input  logic        littleEndian,
  output logic        busReady,
  output laneCtl_t    laneCtl
);

  typedef enum logic {ST_IDLE, ST_LANE} ctrlState_e;

  ctrlState_e state;
  logic [1:0] laneIdx;
  logic [1:0] lastIdx;
  logic       wrLat;
  logic       leLat;
  logic       inRegion;
  logic       accept;

  assign inRegion = (reqAddr - BASE_ADDR) < 32'(REGION_BYTES);
  assign busReady = (state == ST_IDLE);
  assign accept   = reqValid && busReady && inRegion;

  always_comb begin
    laneCtl         = '0;
    laneCtl.capture = accept;
    laneCtl.laneEn  = (state == ST_LANE);
    laneCtl.laneWr  = wrLat;
    laneCtl.laneOff = laneIdx;
    laneCtl.bytePos = leLat ? laneIdx : (lastIdx - laneIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      laneIdx <= '0;
      lastIdx <= '0;
      wrLat   <= 1'b0;
      leLat   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_LANE;
            laneIdx <= '0;
            lastIdx <= lastLaneOf(reqSize);
            wrLat   <= reqWrite;
            leLat   <= littleEndian;
          end
        end
        default: begin
          if (laneIdx == lastIdx) state <= ST_IDLE;
          else                    laneIdx <= laneIdx + 2'd1;
        end
      endcase
    end
  end

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busReady && inRegion) |=> !busReady);

  // R10
  region_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busReady && !inRegion) |=> busReady);

  // R5
  ready_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReady) |-> $past(laneCtl.laneEn && (laneIdx == lastIdx)));

endmodule

// File: rtl/fbw_datapath.sv
module fbw_datapath
  import fbw_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0010_0000,
  parameter int          FRAME_W   = 64,
  parameter int          FRAME_H   = 48,
  parameter int          WIN_W     = 40,
  parameter int          WIN_H     = 11,
  localparam int         DEPTH     = WIN_W * WIN_H,
  localparam int         IDX_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  laneCtl_t         laneCtl,
  input  logic [31:0]      reqAddr,
  input  logic [31:0]      reqWdata,
  input  logic [IDX_W-1:0] scanAddr,
  output logic [31:0]      busRdata,
  output logic             dirtyValid,
  output logic [IDX_W-1:0] dirtyIndex,
  output logic [7:0]       scanData,
  output logic [23:0]      scanGrey
);

  localparam int FW_LOG     = $clog2(FRAME_W);
  localparam int WIN_OFFSET = (FRAME_H - WIN_H) * FRAME_W + (FRAME_W - WIN_W);
  localparam int GREY_CH    = 3;

  logic [7:0]       pixMem [DEPTH];
  logic [31:0]      addrLat;
  logic [31:0]      wdataLat;
  logic [31:0]      rdAcc;
  logic [31:0]      laneAddr;
  logic [31:0]      relAddr;
  logic [31:0]      rowFull;
  logic [31:0]      colFull;
  logic             inWin;
  logic [IDX_W-1:0] pixIdx;
  logic [7:0]       wrByte;
  logic [7:0]       rdByte;
  logic             doWrite;

  // Address translation: full-width unsigned compare, so negative offsets wrap high and fail.
  assign laneAddr = addrLat + 32'(laneCtl.laneOff);
  assign relAddr  = laneAddr - BASE_ADDR - 32'(WIN_OFFSET);
  assign rowFull  = relAddr >> FW_LOG;
  assign colFull  = relAddr & 32'(FRAME_W - 1);
  assign inWin    = (colFull < 32'(WIN_W)) && (rowFull < 32'(WIN_H));
  assign pixIdx   = IDX_W'(rowFull * 32'(WIN_W) + colFull);

  assign wrByte  = wdataLat[{laneCtl.bytePos, 3'b000} +: 8];
  assign rdByte  = inWin ? pixMem[pixIdx] : 8'h00;
  assign doWrite = laneCtl.laneEn && laneCtl.laneWr && inWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat  <= '0;
      wdataLat <= '0;
      rdAcc    <= '0;
    end else if (laneCtl.capture) begin
      addrLat  <= reqAddr;
      wdataLat <= reqWdata;
      rdAcc    <= '0;
    end else if (laneCtl.laneEn && !laneCtl.laneWr) begin
      rdAcc[{laneCtl.bytePos, 3'b000} +: 8] <= rdByte;
    end
  end

  assign busRdata = rdAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) pixMem[i] <= 8'h00;
    end else if (doWrite) begin
      pixMem[pixIdx] <= wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirtyValid <= 1'b0;
      dirtyIndex <= '0;
    end else begin
      dirtyValid <= doWrite;
      dirtyIndex <= pixIdx;
    end
  end

  // Scan-out port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      scanData <= 8'h00;
    else if (32'(scanAddr) < DEPTH) scanData <= pixMem[scanAddr];
    else                            scanData <= 8'h00;
  end

  for (genvar ch = 0; ch < GREY_CH; ch++) begin : g_grey
    assign scanGrey[ch*8 +: 8] = scanData;
  end

  // R9
  dirty_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirtyValid |-> (32'(dirtyIndex) < DEPTH));

  // R9
  dirty_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirtyValid |-> $past(laneCtl.laneEn && laneCtl.laneWr));

  // R2
  stored_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    doWrite |=> (pixMem[$past(pixIdx)] == $past(wrByte)));

endmodule

// File: rtl/fbw_bridge.sv
module fbw_bridge
  import fbw_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR    = 32'h0010_0000,
  parameter int          REGION_BYTES = 4096,
  parameter int          FRAME_W      = 64,
  parameter int          FRAME_H      = 48,
  parameter int          WIN_W        = 40,
  parameter int          WIN_H        = 11,
  localparam int         IDX_W        = $clog2(WIN_W * WIN_H)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             littleEndian,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqSize,
  input  logic [31:0]      reqAddr,
  input  logic [31:0]      reqWdata,
  output logic             busReady,
  output logic [31:0]      busRdata,
  output logic             dirtyValid,
  output logic [IDX_W-1:0] dirtyIndex,
  input  logic [IDX_W-1:0] scanAddr,
  output logic [7:0]       scanData,
  output logic [23:0]      scanGrey
);

  laneCtl_t laneCtl;

  fbw_ctrl #(
    .BASE_ADDR    (BASE_ADDR),
    .REGION_BYTES (REGION_BYTES)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqSize      (reqSize),
    .reqAddr      (reqAddr),
    .littleEndian (littleEndian),
    .busReady     (busReady),
    .laneCtl      (laneCtl)
  );

  fbw_datapath #(
    .BASE_ADDR (BASE_ADDR),
    .FRAME_W   (FRAME_W),
    .FRAME_H   (FRAME_H),
    .WIN_W     (WIN_W),
    .WIN_H     (WIN_H)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .laneCtl    (laneCtl),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .scanAddr   (scanAddr),
    .busRdata   (busRdata),
    .dirtyValid (dirtyValid),
    .dirtyIndex (dirtyIndex),
    .scanData   (scanData),
    .scanGrey   (scanGrey)
  );

endmodule

// File: tb/fbw_bridge_test.sv
`timescale 1ns/1ps
module fbw_bridge_test;

  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam int FW = 64, FH = 48, WW = 40, WH = 11;
  localparam int IDXW = 9;

  logic clk = 0;
  logic rstN = 0;
  logic littleEndian = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [1:0] reqSize = 0;
  logic [31:0] reqAddr = 0, reqWdata = 0;
  logic busReady;
  logic [31:0] busRdata;
  logic dirtyValid;
  logic [IDXW-1:0] dirtyIndex;
  logic [IDXW-1:0] scanAddr = 0;
  logic [7:0] scanData;
  logic [23:0] scanGrey;

  int checks = 0, errors = 0;
  int dirtyCnt = 0;
  int dirtyLog [16];
  bit finished = 0;

  always #2 clk = ~clk;

  fbw_bridge uut (
    .clk(clk), .rstN(rstN), .littleEndian(littleEndian),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busReady(busReady),
    .busRdata(busRdata), .dirtyValid(dirtyValid), .dirtyIndex(dirtyIndex),
    .scanAddr(scanAddr), .scanData(scanData), .scanGrey(scanGrey)
  );

  always @(negedge clk) begin
    if (rstN && dirtyValid) begin
      if (dirtyCnt < 16) dirtyLog[dirtyCnt] = int'(dirtyIndex);
      dirtyCnt++;
    end
  end

  function automatic logic [31:0] pixAddr(input int r, input int c);
    return BASE + 32'((FH - WH + r) * FW + (FW - WW) + c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int lowCycles);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    lowCycles = 0;
    while (!busReady && lowCycles < 20) begin
      lowCycles++;
      @(negedge clk);
    end
    rd = busRdata;
    @(negedge clk);
  endtask

  task automatic scanRead(input int idx, output logic [7:0] d, output logic [23:0] g);
    @(negedge clk);
    scanAddr = IDXW'(idx);
    @(negedge clk);
    d = scanData;
    g = scanGrey;
  endtask

  task automatic testReset();
    logic [7:0] d; logic [23:0] g;
    chk("R1 busReady", 32'(busReady), 1);
    chk("R1 dirtyValid", 32'(dirtyValid), 0);
    scanRead(0, d, g);   chk("R1 slot0", 32'(d), 0);
    scanRead(439, d, g); chk("R1 slot439", 32'(d), 0);
  endtask

  task automatic testByteMap();
    logic [31:0] rd; int lc; logic [7:0] d; logic [23:0] g;
    dirtyCnt = 0;
    busOp(1, 2'd0, pixAddr(3, 7), 32'h0000_005A, rd, lc);
    chk("R5 byte lanes", 32'(lc), 1);
    chk("R9 dirty count", 32'(dirtyCnt), 1);
    chk("R9 dirty index", 32'(dirtyLog[0]), 127);
    scanRead(127, d, g);
    chk("R2 stored", 32'(d), 32'h5A);
    chk("R11 grey", 32'(g), 32'h005A5A5A);
    busOp(0, 2'd0, pixAddr(3, 7), 0, rd, lc);
    chk("R2 read back", rd, 32'h0000_005A);
    chk("R9 no strobe on read", 32'(dirtyCnt), 1);
    busOp(1, 2'd0, pixAddr(0, 0), 32'h11, rd, lc);
    busOp(1, 2'd0, pixAddr(10, 39), 32'h22, rd, lc);
    busOp(1, 2'd0, pixAddr(0, 39), 32'h33, rd, lc);
    busOp(1, 2'd0, pixAddr(10, 0), 32'h44, rd, lc);
    scanRead(0, d, g);   chk("R2 corner r0c0", 32'(d), 32'h11);
    scanRead(439, d, g); chk("R2 corner r10c39", 32'(d), 32'h22);
    scanRead(39, d, g);  chk("R2 corner r0c39", 32'(d), 32'h33);
    scanRead(400, d, g); chk("R2 corner r10c0", 32'(d), 32'h44);
  endtask

  task automatic testColReject();
    logic [31:0] rd; int lc; logic [7:0] d; logic [23:0] g;
    dirtyCnt = 0;
    busOp(1, 2'd0, pixAddr(2, 40), 32'hEE, rd, lc);
    busOp(1, 2'd0, pixAddr(2, 63), 32'hED, rd, lc);
    chk("R3 no strobe", 32'(dirtyCnt), 0);
    busOp(0, 2'd0, pixAddr(2, 40), 0, rd, lc);
    chk("R3 read zero", rd, 0);
    scanRead(120, d, g); chk("R3 neighbour r3c0", 32'(d), 0);
    scanRead(80, d, g);  chk("R3 neighbour r2c0", 32'(d), 0);
  endtask

  task automatic testRowReject();
    logic [31:0] rd; int lc; logic [7:0] d; logic [23:0] g;
    dirtyCnt = 0;
    busOp(1, 2'd0, pixAddr(0, -1), 32'hC1, rd, lc);
    busOp(1, 2'd0, BASE, 32'hC2, rd, lc);
    busOp(1, 2'd0, pixAddr(11, 0), 32'hC3, rd, lc);
    chk("R4 no strobe", 32'(dirtyCnt), 0);
    busOp(0, 2'd0, pixAddr(0, -1), 0, rd, lc);
    chk("R4 read before window", rd, 0);
    busOp(0, 2'd0, pixAddr(11, 0), 0, rd, lc);
    chk("R4 read below window", rd, 0);
    scanRead(0, d, g);   chk("R4 slot0 intact", 32'(d), 32'h11);
    scanRead(439, d, g); chk("R4 slot439 intact", 32'(d), 32'h22);
  endtask

  task automatic testBigEndian();
    logic [31:0] rd; int lc; logic [7:0] d; logic [23:0] g;
    littleEndian = 0;
    dirtyCnt = 0;
    busOp(1, 2'd2, pixAddr(5, 0), 32'h1122_3344, rd, lc);
    chk("R5 word lanes", 32'(lc), 4);
    chk("R9 word strobes", 32'(dirtyCnt), 4);
    for (int k = 0; k < 4; k++) chk("R9 word strobe index", 32'(dirtyLog[k]), 32'(200 + k));
    scanRead(200, d, g); chk("R6 msb at low addr", 32'(d), 32'h11);
    scanRead(203, d, g); chk("R6 lsb at high addr", 32'(d), 32'h44);
    busOp(0, 2'd2, pixAddr(5, 0), 0, rd, lc);
    chk("R6 word read", rd, 32'h1122_3344);
    busOp(0, 2'd1, pixAddr(5, 2), 0, rd, lc);
    chk("R5 half lanes", 32'(lc), 2);
    chk("R6 half read", rd, 32'h0000_3344);
    busOp(0, 2'd3, pixAddr(5, 0), 0, rd, lc);
    chk("R5 size3 lanes", 32'(lc), 4);
    chk("R5 size3 data", rd, 32'h1122_3344);
  endtask

  task automatic testLittleEndian();
    logic [31:0] rd; int lc; logic [7:0] d; logic [23:0] g;
    littleEndian = 1;
    busOp(1, 2'd2, pixAddr(6, 0), 32'hA0B0_C0D0, rd, lc);
    scanRead(240, d, g); chk("R7 lsb at low addr", 32'(d), 32'hD0);
    scanRead(243, d, g); chk("R7 msb at high addr", 32'(d), 32'hA0);
    busOp(0, 2'd2, pixAddr(6, 0), 0, rd, lc);
    chk("R7 word read", rd, 32'hA0B0_C0D0);
    busOp(1, 2'd1, pixAddr(7, 0), 32'h0000_BEEF, rd, lc);
    scanRead(280, d, g); chk("R7 half low", 32'(d), 32'hEF);
    scanRead(281, d, g); chk("R7 half high", 32'(d), 32'hBE);
    littleEndian = 0;
    busOp(0, 2'd2, pixAddr(6, 0), 0, rd, lc);
    chk("R6 cross-order read", rd, 32'hD0C0_B0A0);
  endtask

  task automatic testStraddle();
    logic [31:0] rd; int lc; logic [7:0] d; logic [23:0] g;
    littleEndian = 0;
    dirtyCnt = 0;
    busOp(1, 2'd2, pixAddr(0, 38), 32'hA1B2_C3D4, rd, lc);
    chk("R8 lanes still four", 32'(lc), 4);
    chk("R8 two strobes", 32'(dirtyCnt), 2);
    chk("R8 strobe idx38", 32'(dirtyLog[0]), 38);
    chk("R8 strobe idx39", 32'(dirtyLog[1]), 39);
    scanRead(38, d, g); chk("R8 idx38", 32'(d), 32'hA1);
    scanRead(39, d, g); chk("R8 idx39", 32'(d), 32'hB2);
    scanRead(40, d, g); chk("R8 idx40 untouched", 32'(d), 0);
    busOp(0, 2'd2, pixAddr(0, 38), 0, rd, lc);
    chk("R8 straddle read", rd, 32'hA1B2_0000);
  endtask

  task automatic testRegion();
    logic [31:0] a [2];
    a[0] = BASE + 32'd4096;
    a[1] = BASE - 32'd1;
    foreach (a[i]) begin
      dirtyCnt = 0;
      @(negedge clk);
      reqValid = 1; reqWrite = 1; reqSize = 2'd2; reqAddr = a[i]; reqWdata = 32'hFFFF_FFFF;
      @(negedge clk);
      chk("R10 not accepted", 32'(busReady), 1);
      reqValid = 0;
      repeat (6) @(negedge clk);
      chk("R10 still idle", 32'(busReady), 1);
      chk("R10 no strobe", 32'(dirtyCnt), 0);
    end
  endtask

  task automatic testScanRange();
    logic [7:0] d; logic [23:0] g;
    scanRead(500, d, g);
    chk("R11 out of range data", 32'(d), 0);
    chk("R11 out of range grey", 32'(g), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testByteMap();
    testColReject();
    testRowReject();
    testBigEndian();
    testLittleEndian();
    testStraddle();
    testRegion();
    testScanRange();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule